// File: doc/BRIEF.md
# Signed Sequential Restoring Divider

This block divides one 8-bit two's-complement number by another over several clock cycles and returns an 8-bit signed quotient and remainder. Both operands are first reduced to unsigned magnitudes. One subtractor then performs a trial subtraction of the divisor from a partial remainder once per iteration. Each result bit comes from the subtractor's carry. When the operation ends, the signs are put back.

Internally, the dividend magnitude sits in a shift register that turns into the quotient as it shifts. This register acts on the falling clock edge. The partial remainder acts on the rising edge, so each new quotient bit has settled before the shift that takes it in. When a trial subtraction succeeds, the partial remainder loads the subtractor output already moved up one place, so the load and the shift happen in one cycle. A down-counter runs exactly eight iterations.

A user pulses `start` with the operands while the block is idle. `done` then marks the cycle from which the results and error flags are valid.

Top module: `signed_seq_divider`

## Requirements
- R1: The signs of the operands do not affect the magnitudes computed. For example, ±101 divided by ±5 always gives a quotient of magnitude 20 and a remainder of magnitude 1.
- R2: The quotient is rounded toward zero and is negative exactly when the two operand signs differ. The remainder takes the sign of the dividend, and its magnitude is below the divisor's magnitude.
- R3: `start` is sampled on a rising edge while `busy` is 0.
  - `busy` is then 1 for exactly 9 cycles.
  - `done` is 1 for one cycle, starting at the edge where `busy` falls.
  - From that edge on, `quotient`, `remainder`, `err_ovf` and `err_div0` are valid and hold until the next completion.
- R4: A `start` pulse while `busy` is 1 is ignored. The running operation completes with its original operands.
- R5: For the dividend -128 (0x80) and the divisor -1 (0xFF), `err_ovf` is 1, `quotient` is 0x80 and `remainder` is 0. Otherwise `err_ovf` is 0.
- R6: For a divisor of 0, `err_div0` is 1, `quotient` is 0xFF and `remainder` equals the dividend. Otherwise `err_div0` is 0.
- R7: After reset, `busy`, `done`, `err_ovf` and `err_div0` are 0, and `quotient` and `remainder` are 0.
- R8: The iteration counter loads 8 on an accepted start and falls by one on each iteration.
- R9: After each iteration, the partial remainder is below twice the divisor magnitude, for any nonzero divisor.
- R10: The dividend/quotient register takes the dividend magnitude on the falling edge of the cycle in which the start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; sampled while idle |
| dividend | input | 8 | Signed dividend |
| divisor | input | 8 | Signed divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 8 | Signed quotient |
| remainder | output | 8 | Signed remainder |
| err_ovf | output | 1 | Quotient +128 cannot be represented |
| err_div0 | output | 1 | Divisor was zero |

## Verification
A quotient bit taken in on the wrong edge, or a partial remainder that misses a restore, shows up as a wrong `quotient` or `remainder` in the first `done` cycle of any affected division. A counter off by one changes the 9-cycle `busy` window and shifts every later bit position, so it is visible in the same operation. The bench sweeps every dividend against a set of divisors that covers the sign, zero, ±1 and extreme-magnitude cases, comparing each result with integer arithmetic. A start raised mid-operation tests that the captured operands stay held.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  parameter int unsigned DIV_W = 8;
  localparam int unsigned CNT_W = $clog2(DIV_W + 1);

  typedef struct packed {
    logic             carry;
    logic [DIV_W-1:0] diff;
  } trial_t;

  // Unsigned magnitude of a two's-complement value (most negative maps to 2^(W-1)).
  function automatic logic [DIV_W-1:0] magnitude(input logic [DIV_W-1:0] v);
    return v[DIV_W-1] ? (~v + 1'b1) : v;
  endfunction

  // Re-apply a sign to a magnitude.
  function automatic logic [DIV_W-1:0] apply_sign(input logic [DIV_W-1:0] m, input logic neg);
    return neg ? (~m + 1'b1) : m;
  endfunction

  // Trial subtraction; carry = 1 means no borrow.
  function automatic trial_t trial_sub(input logic [DIV_W-1:0] a, input logic [DIV_W-1:0] b);
    logic [DIV_W:0] s;
    s = {1'b0, a} + {1'b0, ~b} + {{DIV_W{1'b0}}, 1'b1};
    return '{carry: s[DIV_W], diff: s[DIV_W-1:0]};
  endfunction
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int unsigned W = sdiv_pkg::DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] d_mag,
  output logic         q_neg,
  output logic         r_neg,
  output logic         ovf,
  output logic         dz
);
  import sdiv_pkg::*;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_mag <= '0;
      d_mag <= '0;
      q_neg <= 1'b0;
      r_neg <= 1'b0;
      ovf   <= 1'b0;
      dz    <= 1'b0;
    end else if (capture) begin
      a_mag <= magnitude(dividend);
      d_mag <= magnitude(divisor);
      q_neg <= dividend[W-1] ^ divisor[W-1];
      r_neg <= dividend[W-1];
      ovf   <= (dividend == MOST_NEG) && (divisor == {W{1'b1}});
      dz    <= (divisor == '0);
    end
  end
endmodule

// File: rtl/div_seq_ctrl.sv
module div_seq_ctrl #(
  parameter int unsigned W  = sdiv_pkg::DIV_W,
  parameter int unsigned CW = sdiv_pkg::CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic capture,
  output logic load_q,
  output logic shift_q,
  output logic step,
  output logic finish,
  output logic done
);
  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign capture  = start && !busy;
  assign step     = busy && !cnt_zero;
  assign finish   = busy && cnt_zero;
  assign shift_q  = busy && !load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      load_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done   <= finish;
      load_q <= capture;          // delayed load enable, held to the falling edge
      if (capture) begin
        busy <= 1'b1;
        cnt  <= CW'(W);
      end else if (busy) begin
        if (cnt_zero) busy <= 1'b0;
        else          cnt  <= cnt - 1'b1;
      end
    end
  end

  assert_count_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (cnt == CW'(W)));
  assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt == $past(cnt) - 1'b1));
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_single_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q);
endmodule

// File: rtl/div_rem_path.sv
module div_rem_path #(
  parameter int unsigned W = sdiv_pkg::DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         q_msb,
  input  logic [W-1:0] d_mag,
  output logic         carry,
  output logic [W-1:0] rem_mag
);
  import sdiv_pkg::*;
  logic [W-1:0] pr;
  trial_t       t;

  assign t       = trial_sub(pr, d_mag);
  assign carry   = t.carry;
  assign rem_mag = t.carry ? t.diff : pr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pr <= '0;
    else if (clear) pr <= '0;
    else if (step) begin
      if (t.carry) pr <= {t.diff[W-2:0], q_msb};   // load, pre-shifted by one
      else         pr <= {pr[W-2:0], q_msb};
    end
  end

  assert_pr_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (d_mag != '0)) |=> ({1'b0, pr} < {d_mag, 1'b0}));
endmodule

// File: rtl/div_quot_reg.sv
module div_quot_reg #(
  parameter int unsigned W = sdiv_pkg::DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] a_mag,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= a_mag;
    else if (shift) q <= {q[W-2:0], bit_in};
  end

  assert_load_falling_R10: assert property (@(negedge clk) disable iff (!rst_n)
    load |=> (q == $past(a_mag)));
endmodule

// File: rtl/signed_seq_divider.sv
module signed_seq_divider #(
  parameter int unsigned W = sdiv_pkg::DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         err_ovf,
  output logic         err_div0
);
  import sdiv_pkg::*;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic         capture, load_q, shift_q, step, finish;
  logic [W-1:0] a_mag, d_mag, q_reg, rem_mag;
  logic         q_neg, r_neg, ovf, dz, carry;

  div_seq_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .capture(capture),
    .load_q(load_q), .shift_q(shift_q), .step(step), .finish(finish), .done(done)
  );

  div_operand_prep #(.W(W)) u_prep (
    .clk(clk), .rst_n(rst_n), .capture(capture), .dividend(dividend), .divisor(divisor),
    .a_mag(a_mag), .d_mag(d_mag), .q_neg(q_neg), .r_neg(r_neg), .ovf(ovf), .dz(dz)
  );

  div_rem_path #(.W(W)) u_rem (
    .clk(clk), .rst_n(rst_n), .clear(capture), .step(step), .q_msb(q_reg[W-1]),
    .d_mag(d_mag), .carry(carry), .rem_mag(rem_mag)
  );

  div_quot_reg #(.W(W)) u_quot (
    .clk(clk), .rst_n(rst_n), .load(load_q), .shift(shift_q), .a_mag(a_mag),
    .bit_in(carry), .q(q_reg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotient  <= '0;
      remainder <= '0;
      err_ovf   <= 1'b0;
      err_div0  <= 1'b0;
    end else if (finish) begin
      quotient  <= dz ? {W{1'b1}} : apply_sign(q_reg, q_neg);
      remainder <= apply_sign(rem_mag, r_neg);
      err_ovf   <= ovf;
      err_div0  <= dz;
    end
  end

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_ovf_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_ovf) |-> ((quotient == MOST_NEG) && (remainder == '0)));
  assert_div0_quot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_div0) |-> (quotient == {W{1'b1}}));
endmodule

// File: tb/sim_signed_seq_divider.sv
module sim_signed_seq_divider;
  localparam int CLK_P = 10;
  localparam int LIMIT = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] dividend = '0, divisor = '0;
  logic       busy, done, err_ovf, err_div0;
  logic [7:0] quotient, remainder;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  signed_seq_divider u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .err_ovf(err_ovf), .err_div0(err_div0)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
      finish_run();
    end
  end

  function automatic void model(input logic [7:0] a, input logic [7:0] b,
                                output logic [7:0] q, output logic [7:0] r,
                                output bit ov, output bit dz);
    int ai, bi;
    ai = $signed(a);
    bi = $signed(b);
    ov = (ai == -128) && (bi == -1);
    dz = (bi == 0);
    if (dz)      begin q = 8'hFF; r = a;     end
    else if (ov) begin q = 8'h80; r = 8'h00; end
    else begin
      q = 8'(ai / bi);
      r = 8'(ai % bi);
    end
  endfunction

  // One division; optionally a second start during busy (R4).
  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input bit poke);
    logic [7:0] eq, er;
    bit eov, edz, busy_ok;
    model(a, b, eq, er, eov, edz);
    @(posedge clk); #1;
    start = 1'b1; dividend = a; divisor = b;
    @(posedge clk); #1;
    start = 1'b0;
    busy_ok = busy && !done;
    for (int k = 0; k < 8; k++) begin
      if (poke && k == 3) begin
        start = 1'b1; dividend = ~a; divisor = b + 8'd3;
      end
      @(posedge clk); #1;
      start = 1'b0;
      busy_ok &= busy && !done;
    end
    check(busy_ok, "R3 busy window", int'(busy), 1);
    @(posedge clk); #1;
    check(!busy && done, "R3 done edge", int'({busy, done}), 1);
    check(quotient == eq, poke ? "R4 quotient" : "R1 R2 quotient", int'(quotient), int'(eq));
    check(remainder == er, poke ? "R4 remainder" : "R2 R9 remainder", int'(remainder), int'(er));
    check(err_ovf == eov, "R5 overflow flag", int'(err_ovf), int'(eov));
    check(err_div0 == edz, "R6 div0 flag", int'(err_div0), int'(edz));
    @(posedge clk); #1;
    check(!done && quotient == eq, "R3 done pulse and hold", int'({done, quotient}), int'(eq));
  endtask

  initial begin
    logic [7:0] dlist [16];
    dlist = '{8'h00, 8'h01, 8'hFF, 8'h02, 8'hFE, 8'h03, 8'h05, 8'hFB,
              8'h07, 8'hF9, 8'h0D, 8'h40, 8'h7F, 8'h81, 8'h80, 8'h64};
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !done && !err_ovf && !err_div0, "R7 reset flags",
          int'({busy, done, err_ovf, err_div0}), 0);
    check(quotient == 0 && remainder == 0, "R7 reset data",
          int'({quotient, remainder}), 0);
    rst_n = 1'b1;
    // R1 sign independence of magnitudes: +-101 / +-5
    run_op(8'd101, 8'd5, 1'b0);
    run_op(8'(-101), 8'd5, 1'b0);
    run_op(8'd101, 8'(-5), 1'b0);
    run_op(8'(-101), 8'(-5), 1'b0);
    // R5 and R6 corners, R10 load of the extreme magnitude
    run_op(8'h80, 8'hFF, 1'b0);
    run_op(8'h80, 8'h00, 1'b0);
    run_op(8'h80, 8'h01, 1'b0);
    // R4 start during busy
    run_op(8'd77, 8'd6, 1'b1);
    run_op(8'h90, 8'hFD, 1'b1);
    // R2 R8 sweep: every dividend against the divisor set
    for (int i = 0; i < 16; i++)
      for (int a = 0; a < 256; a++)
        run_op(8'(a), dlist[i], 1'b0);
    finish_run();
  end
endmodule